// File: doc/BRIEF.md
# Thermostat with Fault-Count Filter

This block paces temperature conversions and turns their results into a filtered over-temperature line. An internal timer sets the conversion period. The period depends on the selected result resolution and on a parameter that gives the number of clock cycles per millisecond. At the end of each period the block takes a signed sample from its sample input. It clears the bits below the selected resolution, stores the result as the temperature word and pulses a done strobe for one cycle.

Each stored result is compared with two signed limits: a high trip threshold and a lower hysteresis threshold. The alarm line changes state only after a run of consecutive qualifying results. The run length is chosen by a 2-bit fault field. A result that does not qualify for the pending transition ends the run. Changing the fault field also ends the run. The analog converter is not part of the block. Its output arrives on the sample input.

Top module: `therm_ctrl`

## Requirements
- R1: While reset is active, and right after it, `temp_word` is zero and `alarm` and `conv_done` are low.
- R2: `conv_done` is a one-cycle pulse. While `res_sel` is held, pulses are exactly CYC_PER_MS*25*2^res_sel cycles apart, so the periods are 25, 50, 100 and 200 ms for codes 0, 1, 2 and 3. The first pulse after reset release comes that many cycles after release.
- R3: When a conversion ends, `temp_word` takes `sample_in` with its low 7-res_sel bits forced to zero, keeping 9, 10, 11 or 12 bits for codes 0 to 3. Between conversions `temp_word` holds its value.
- R4: A low `alarm` rises once N consecutive stored results are signed-greater-than-or-equal to `thr_hi`. N is 1, 2, 4 or 6 for `fault_sel` codes 0, 1, 2 and 3.
- R5: A high `alarm` falls once N consecutive stored results are signed-less-than `thr_lo`. A result equal to `thr_lo` does not count.
- R6: A result that fails the condition for the pending transition sets the consecutive count back to zero.
- R7: A change of `fault_sel` sets the consecutive count back to zero. A result taken in that same cycle counts as the first of a new run.
- R8: `alarm` changes only in the cycle where `conv_done` is high, together with the new `temp_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_sel | input | 2 | Resolution code, 0 = 9 bits up to 3 = 12 bits |
| fault_sel | input | 2 | Consecutive-result code, 0/1/2/3 = 1/2/4/6 |
| thr_hi | input | 16 | Signed high trip threshold, same format as temp_word |
| thr_lo | input | 16 | Signed hysteresis threshold |
| sample_in | input | 16 | Signed left-justified converter sample, 1/16 °C per LSB at bit 4 |
| temp_word | output | 16 | Last stored, truncated result |
| alarm | output | 1 | Filtered over-temperature line |
| conv_done | output | 1 | One-cycle strobe when a result is stored |

## Verification
The bench checks results that sit exactly on each threshold. A design using the wrong comparison would trip one result late on `thr_hi` or release early on `thr_lo`. It feeds samples whose masked-off bits would cross a limit, which catches truncation applied after the compare or to the wrong bit count. Each fault run is broken one result short, and a fault-code change is made partway through a run. A design that kept a stale count would trip after fewer than N results. The timer period is measured at the shortest and longest resolutions, and the bench confirms that the alarm is still unchanged in the cycle before the strobe. These two checks expose off-by-one periods and early alarm updates.

// File: rtl/therm_pkg.sv
package therm_pkg;
    localparam int TEMP_W   = 16;
    localparam int MIN_BITS = 9;
    localparam int DROP_MAX = TEMP_W - MIN_BITS;
    localparam int RUN_MAX  = 6;
    localparam int RUN_W    = $clog2(RUN_MAX + 1);

    typedef struct packed {
        logic             alarm;
        logic [RUN_W-1:0] run;
        logic [1:0]       fsel;
    } filt_st_t;

    typedef struct packed {
        logic [TEMP_W-1:0] temp;
        logic              done;
    } out_st_t;

    // Keep-mask for a resolution code: the low (DROP_MAX - code) bits are cleared.
    function automatic logic [TEMP_W-1:0] res_mask(input logic [1:0] code);
        return {TEMP_W{1'b1}} << (DROP_MAX - int'(code));
    endfunction

    // Consecutive results needed for a fault code.
    function automatic logic [RUN_W-1:0] need_runs(input logic [1:0] code);
        case (code)
            2'd0:    return RUN_W'(1);
            2'd1:    return RUN_W'(2);
            2'd2:    return RUN_W'(4);
            default: return RUN_W'(RUN_MAX);
        endcase
    endfunction
endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CYC_PER_MS = 1000,
    parameter int BASE_MS    = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] res_sel,
    output logic       tick
);
    localparam int BASE_CYC = CYC_PER_MS * BASE_MS;
    localparam int CW       = $clog2(BASE_CYC * 8 + 1);

    logic [CW-1:0] lim;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        lim   = CW'(BASE_CYC) << res_sel;
        // ">=" keeps a shortened period from overshooting after a mid-count change
        tick  = (cnt_q >= lim - CW'(1));
        cnt_d = tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fault_filter.sv
module fault_filter
    import therm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [TEMP_W-1:0] sample,
    input  logic [TEMP_W-1:0] thr_hi,
    input  logic [TEMP_W-1:0] thr_lo,
    input  logic [1:0]        fsel,
    output logic              alarm
);
    filt_st_t         st_d, st_q;
    logic [RUN_W-1:0] base;
    logic [RUN_W-1:0] next_run;
    logic             hit;

    always_comb begin
        st_d      = st_q;
        st_d.fsel = fsel;
        base      = (fsel != st_q.fsel) ? '0 : st_q.run;
        st_d.run  = base;
        next_run  = base + RUN_W'(1);
        hit       = st_q.alarm ? ($signed(sample) <  $signed(thr_lo))
                               : ($signed(sample) >= $signed(thr_hi));
        if (valid) begin
            if (!hit) begin
                st_d.run = '0;
            end else if (next_run >= need_runs(fsel)) begin
                st_d.alarm = ~st_q.alarm;
                st_d.run   = '0;
            end else begin
                st_d.run = next_run;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm = st_q.alarm;
endmodule

// File: rtl/therm_ctrl.sv
module therm_ctrl
    import therm_pkg::*;
#(
    parameter int CYC_PER_MS = 1000,
    parameter int BASE_MS    = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        res_sel,
    input  logic [1:0]        fault_sel,
    input  logic [TEMP_W-1:0] thr_hi,
    input  logic [TEMP_W-1:0] thr_lo,
    input  logic [TEMP_W-1:0] sample_in,
    output logic [TEMP_W-1:0] temp_word,
    output logic              alarm,
    output logic              conv_done
);
    logic              tick;
    logic [TEMP_W-1:0] masked;
    out_st_t           out_d, out_q;

    conv_timer #(.CYC_PER_MS(CYC_PER_MS), .BASE_MS(BASE_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .res_sel (res_sel),
        .tick    (tick)
    );

    fault_filter u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (tick),
        .sample (masked),
        .thr_hi (thr_hi),
        .thr_lo (thr_lo),
        .fsel   (fault_sel),
        .alarm  (alarm)
    );

    always_comb begin
        masked     = sample_in & res_mask(res_sel);
        out_d      = out_q;
        out_d.done = tick;
        if (tick) out_d.temp = masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign temp_word = out_q.temp;
    assign conv_done = out_q.done;
endmodule

// File: rtl/therm_ctrl_chk.sv
module therm_ctrl_chk
    import therm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        res_sel,
    input logic [TEMP_W-1:0] thr_hi,
    input logic [TEMP_W-1:0] thr_lo,
    input logic [TEMP_W-1:0] temp_word,
    input logic              alarm,
    input logic              conv_done
);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> ((temp_word & ~res_mask($past(res_sel))) == '0));

    p_temp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |-> $stable(temp_word));

    p_rise_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> ($signed(temp_word) >= $signed($past(thr_hi))));

    p_fall_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |-> ($signed(temp_word) < $signed($past(thr_lo))));

    p_alarm_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alarm) |-> conv_done);
endmodule

bind therm_ctrl therm_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_sel   (res_sel),
    .thr_hi    (thr_hi),
    .thr_lo    (thr_lo),
    .temp_word (temp_word),
    .alarm     (alarm),
    .conv_done (conv_done)
);

// File: tb/tb_therm_ctrl.sv
module tb_therm_ctrl;
    localparam int CPM = 2;
    localparam int P0  = CPM * 25;

    typedef struct packed {
        logic [1:0]  r;
        logic [1:0]  f;
        logic [15:0] s;
        logic [15:0] t;
        logic        a;
    } vec_t;

    // res, fault, sample, expected temp_word, expected alarm after the result
    localparam vec_t VEC [0:20] = '{
        '{2'd0, 2'd0, 16'h1A37, 16'h1A00, 1'b0},
        '{2'd0, 2'd0, 16'h1E05, 16'h1E00, 1'b1},
        '{2'd0, 2'd0, 16'h1C00, 16'h1C00, 1'b1},
        '{2'd0, 2'd0, 16'h18FF, 16'h1880, 1'b0},
        '{2'd1, 2'd1, 16'h2000, 16'h2000, 1'b0},
        '{2'd1, 2'd1, 16'h1000, 16'h1000, 1'b0},
        '{2'd1, 2'd1, 16'h1E3F, 16'h1E00, 1'b0},
        '{2'd1, 2'd1, 16'h1E7F, 16'h1E40, 1'b1},
        '{2'd2, 2'd2, 16'h0000, 16'h0000, 1'b1},
        '{2'd2, 2'd2, 16'hFF10, 16'hFF00, 1'b1},
        '{2'd2, 2'd2, 16'h1900, 16'h1900, 1'b1},
        '{2'd2, 2'd2, 16'h18E0, 16'h18E0, 1'b1},
        '{2'd2, 2'd2, 16'h18E0, 16'h18E0, 1'b1},
        '{2'd2, 2'd2, 16'h18E0, 16'h18E0, 1'b1},
        '{2'd2, 2'd2, 16'h18FF, 16'h18E0, 1'b0},
        '{2'd3, 2'd3, 16'h1E0F, 16'h1E00, 1'b0},
        '{2'd3, 2'd3, 16'h1E0F, 16'h1E00, 1'b0},
        '{2'd3, 2'd3, 16'h1E0F, 16'h1E00, 1'b0},
        '{2'd3, 2'd3, 16'h1E0F, 16'h1E00, 1'b0},
        '{2'd3, 2'd3, 16'h1E0F, 16'h1E00, 1'b0},
        '{2'd3, 2'd3, 16'h1E0F, 16'h1E00, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  res_sel = 2'd0;
    logic [1:0]  fault_sel = 2'd0;
    logic [15:0] thr_hi = 16'h1E00;   // 30 C
    logic [15:0] thr_lo = 16'h1900;   // 25 C
    logic [15:0] sample_in = 16'h0000;
    logic [15:0] temp_word;
    logic        alarm;
    logic        conv_done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    therm_ctrl #(.CYC_PER_MS(CPM)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_sel   (res_sel),
        .fault_sel (fault_sel),
        .thr_hi    (thr_hi),
        .thr_lo    (thr_lo),
        .sample_in (sample_in),
        .temp_word (temp_word),
        .alarm     (alarm),
        .conv_done (conv_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Waits at negedges until conv_done; returns the number of negedges waited.
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!conv_done && n < 2000);
        if (!conv_done) chk("R2 strobe timeout", 0, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int n;
        #5;
        // R1 reset state
        chk("R1 temp in reset", temp_word, 0);
        chk("R1 alarm in reset", alarm, 0);
        chk("R1 done in reset", conv_done, 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 temp after release", temp_word, 0);
        // R2 first period and spacing at 9 bits
        wait_done(n);
        chk("R2 first period res0", n, P0);
        wait_done(n);
        chk("R2 spacing res0", n, P0);
        @(negedge clk);
        chk("R2 single-cycle strobe", conv_done, 0);
        wait_done(n);

        // Table walk: R3 truncation, R4 trip, R5 release, R6 run break
        for (int i = 0; i < 21; i++) begin
            res_sel   = VEC[i].r;
            fault_sel = VEC[i].f;
            sample_in = VEC[i].s;
            wait_done(n);
            chk($sformatf("R3 temp vec %0d", i), temp_word, VEC[i].t);
            chk($sformatf("R4 R5 R6 alarm vec %0d", i), alarm, VEC[i].a);
        end
        // R2 spacing at 12 bits
        wait_done(n);
        chk("R2 spacing res3", n, P0 * 8);

        // R3 hold between conversions
        sample_in = 16'h7FF0;
        repeat (10) @(negedge clk);
        chk("R3 hold between results", temp_word, 16'h1E00);

        // R7 fault-code change mid-run
        do_reset();
        res_sel   = 2'd0;
        fault_sel = 2'd2;
        sample_in = 16'h1E00;       // equal to thr_hi, counts toward trip
        repeat (3) wait_done(n);
        chk("R4 run of three with N=4", alarm, 0);
        fault_sel = 2'd3;           // clears the run
        repeat (5) wait_done(n);
        chk("R7 run cleared by fault-code change", alarm, 0);
        repeat (P0 - 1) @(negedge clk);
        chk("R8 alarm unchanged before strobe", alarm, 0);
        chk("R2 no strobe one cycle early", conv_done, 0);
        @(negedge clk);
        chk("R2 strobe on time", conv_done, 1);
        chk("R7 trip after six new results", alarm, 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule